// File: doc/BRIEF.md
# Indirect Extended Register Window

This block opens a window from a small, directly addressed register port onto a much larger extended register space. It sits behind a management slave (typically the register side of an MDIO slave) and in front of an extended register file. Two direct addresses belong to it: a control register at address 13 and a window register at address 14. All other direct addresses are left to other logic and read as zero here.

The control register holds a two-bit function code in bits [15:14] and a five-bit device address in bits [4:0]. The block keeps a 16-bit extended pointer. An access to the window register goes to one of two places. It can read or write the pointer itself. Otherwise it reads or writes the extended register the pointer selects. The function code decides which, and also decides whether the pointer then advances. The usual sequence writes 0x001F to the control register and then the target address to the window register. Software then writes 0x401F, 0x801F or 0xC01F to the control register and moves data through the window register.

Top module: `xreg_window`

## Requirements
- R1: After reset the control register reads 0x0000 and the extended pointer is 0x0000.
- R2: A direct write to address 13 stores all 16 bits in the control register. A direct read of address 13 returns the last value written.
- R3: With function code 00 (control bits [15:14]) and device address 31 (control bits [4:0]), a write to address 14 loads the pointer and a read of address 14 returns the pointer. The extended port is not strobed, and repeated writes keep overwriting the pointer.
- R4: With function code 01 and device address 31, a read or write of address 14 drives one extended port strobe at the current pointer. A read returns `ext_rdata` and a write passes the direct write data. The pointer does not change, so repeated accesses hit the same extended register.
- R5: With function code 10 and device address 31, each read or write of address 14 uses the current pointer. The pointer advances by one on the following clock edge.
- R6: With function code 11 and device address 31, a write of address 14 advances the pointer after the access. A read leaves the pointer unchanged.
- R7: When the control device address is not 31, accesses to address 14 are ignored. No extended strobe is driven, a read returns 0, and neither the pointer nor any register changes.
- R8: In function codes 01, 10 and 11, an access whose pointer equals 13 or 14 does not strobe the extended port, and a read returns 0. The pointer still follows the advance rule of the function code.
- R9: The pointer wraps from 0xFFFF to 0x0000 when it advances.
- R10: Direct accesses to any address other than 13 or 14 read 0 and change neither the control register nor the pointer.
- R11: A cycle with both `dir_wr` and `dir_rd` high is handled as a write only. At most one extended strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_wr | input | 1 | Direct write strobe, one cycle per access |
| dir_rd | input | 1 | Direct read strobe, one cycle per access |
| dir_addr | input | 5 | Direct register address |
| dir_wdata | input | 16 | Direct write data |
| dir_rdata | output | 16 | Direct read data, valid in the cycle of `dir_rd`, zero otherwise |
| ext_wr | output | 1 | Extended register write strobe |
| ext_rd | output | 1 | Extended register read strobe |
| ext_addr | output | 16 | Extended register address (the pointer) |
| ext_wdata | output | 16 | Extended register write data |
| ext_rdata | input | 16 | Extended register read data, combinational from `ext_addr` |

## Verification
On every cycle the assertions check four things. The two extended strobes never fire together, and a strobe only appears under device address 31 with a pointer outside 13 and 14. In the advancing mode the pointer moves by exactly one after a window access. The pointer stays put for no-advance accesses, for reads in the write-advance mode, and for foreign direct addresses. Other behaviour needs the bench scenarios. These include the values returned by reads, the pointer value that a data access actually presents, and the load value in pointer mode. The bench also covers wrap-around and the silence of the extended port for every rejected device address, sweeping all function codes, all device addresses and both directions.

// File: rtl/xw_pkg.sv
// Shared types for the indirect extended register window.
// Assumes a 16-bit control register with the function code in its two top bits.
package xw_pkg;
    typedef enum logic [1:0] {
        FN_PTR    = 2'b00,
        FN_DATA   = 2'b01,
        FN_INC_RW = 2'b10,
        FN_INC_W  = 2'b11
    } xw_fn_e;

    localparam int DEVAD_W = 5;
endpackage

// File: rtl/xw_ctrl_reg.sv
// Control register: stores the full written word and splits out the
// function code and device address. Assumes DATA_W >= DEVAD_W + 2.
module xw_ctrl_reg
    import xw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   ctrl_q,
    output xw_fn_e              fn,
    output logic [DEVAD_W-1:0]  devad
);
    // Hold the last value written; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wdata;
    end

    // Field extraction.
    always_comb begin
        fn    = xw_fn_e'(ctrl_q[DATA_W-1 -: 2]);
        devad = ctrl_q[DEVAD_W-1:0];
    end
endmodule

// File: rtl/xw_pointer.sv
// Extended address pointer: loadable, advances by one with natural wrap.
// Assumes load and advance are never requested in the same cycle (decoder guarantees).
module xw_pointer #(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PTR_W-1:0]  load_val,
    input  logic              inc,
    output logic [PTR_W-1:0]  ptr_q
);
    // Load has precedence; the advance wraps modulo 2**PTR_W.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (load) ptr_q <= load_val;
        else if (inc)  ptr_q <= ptr_q + PTR_W'(1);
    end
endmodule

// File: rtl/xw_decode.sv
// Access decoder: turns one direct strobe into control write, pointer load,
// pointer advance, extended strobes and read-mux selects.
// Assumes one access per strobe cycle; a write masks a simultaneous read.
module xw_decode
    import xw_pkg::*;
#(
    parameter int DIR_AW    = 5,
    parameter int PTR_W     = 16,
    parameter int CTRL_ADDR = 13,
    parameter int DATA_ADDR = 14,
    parameter int DEVAD_OK  = 31
) (
    input  logic               dir_wr,
    input  logic               dir_rd,
    input  logic [DIR_AW-1:0]  dir_addr,
    input  xw_fn_e             fn,
    input  logic [DEVAD_W-1:0] devad,
    input  logic [PTR_W-1:0]   ptr,
    output logic               ctrl_we,
    output logic               ptr_load,
    output logic               ptr_inc,
    output logic               ext_wr,
    output logic               ext_rd,
    output logic               sel_ctrl,
    output logic               sel_ptr,
    output logic               sel_ext
);
    logic is_wr, is_rd, hit_ctrl, hit_data, dev_ok, win_acc, ptr_mode, self_tgt, ext_go;

    // Classify the access and the state of the window.
    always_comb begin
        is_wr    = dir_wr;
        is_rd    = dir_rd & ~dir_wr;
        hit_ctrl = (dir_addr == DIR_AW'(CTRL_ADDR));
        hit_data = (dir_addr == DIR_AW'(DATA_ADDR));
        dev_ok   = (devad == DEVAD_W'(DEVAD_OK));
        win_acc  = hit_data & dev_ok & (is_wr | is_rd);
        ptr_mode = (fn == FN_PTR);
        self_tgt = (ptr == PTR_W'(CTRL_ADDR)) | (ptr == PTR_W'(DATA_ADDR));
        ext_go   = win_acc & ~ptr_mode & ~self_tgt;
    end

    // Produce the actions for this access.
    always_comb begin
        ctrl_we  = is_wr & hit_ctrl;
        ptr_load = win_acc & ptr_mode & is_wr;
        ptr_inc  = win_acc & ((fn == FN_INC_RW) | ((fn == FN_INC_W) & is_wr));
        ext_wr   = ext_go & is_wr;
        ext_rd   = ext_go & is_rd;
        sel_ctrl = is_rd & hit_ctrl;
        sel_ptr  = is_rd & win_acc & ptr_mode;
        sel_ext  = ext_go & is_rd;
    end
endmodule

// File: rtl/xreg_window.sv
// Top: indirect window onto an extended register space via a control
// register and a window register on a direct register port.
// Assumes ext_rdata is valid combinationally in the cycle ext_rd is high.
module xreg_window
    import xw_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int DIR_AW    = 5,
    parameter int CTRL_ADDR = 13,
    parameter int DATA_ADDR = 14,
    parameter int DEVAD_OK  = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_wr,
    input  logic               dir_rd,
    input  logic [DIR_AW-1:0]  dir_addr,
    input  logic [DATA_W-1:0]  dir_wdata,
    output logic [DATA_W-1:0]  dir_rdata,
    output logic               ext_wr,
    output logic               ext_rd,
    output logic [DATA_W-1:0]  ext_addr,
    output logic [DATA_W-1:0]  ext_wdata,
    input  logic [DATA_W-1:0]  ext_rdata
);
    localparam int PTR_W = DATA_W;

    logic [DATA_W-1:0]  ctrl_q;
    xw_fn_e             fn;
    logic [DEVAD_W-1:0] devad;
    logic [PTR_W-1:0]   ptr_q;
    logic ctrl_we, ptr_load, ptr_inc, sel_ctrl, sel_ptr, sel_ext;

    xw_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_we), .wdata(dir_wdata),
        .ctrl_q(ctrl_q), .fn(fn), .devad(devad)
    );

    xw_pointer #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(dir_wdata),
        .inc(ptr_inc), .ptr_q(ptr_q)
    );

    xw_decode #(
        .DIR_AW(DIR_AW), .PTR_W(PTR_W), .CTRL_ADDR(CTRL_ADDR),
        .DATA_ADDR(DATA_ADDR), .DEVAD_OK(DEVAD_OK)
    ) u_dec (
        .dir_wr(dir_wr), .dir_rd(dir_rd), .dir_addr(dir_addr),
        .fn(fn), .devad(devad), .ptr(ptr_q),
        .ctrl_we(ctrl_we), .ptr_load(ptr_load), .ptr_inc(ptr_inc),
        .ext_wr(ext_wr), .ext_rd(ext_rd),
        .sel_ctrl(sel_ctrl), .sel_ptr(sel_ptr), .sel_ext(sel_ext)
    );

    // Extended port carries the pre-advance pointer and the direct write data.
    always_comb begin
        ext_addr  = ptr_q;
        ext_wdata = dir_wdata;
    end

    // Read-back mux; zero when nothing of ours is read.
    always_comb begin
        if (sel_ctrl)     dir_rdata = ctrl_q;
        else if (sel_ptr) dir_rdata = ptr_q;
        else if (sel_ext) dir_rdata = ext_rdata;
        else              dir_rdata = '0;
    end
endmodule

// File: rtl/xw_checker.sv
// Cycle-by-cycle properties of the window, bound into xreg_window.
// Assumes the default field layout: function in [15:14], device address in [4:0].
module xw_checker #(
    parameter int DATA_W    = 16,
    parameter int DIR_AW    = 5,
    parameter int CTRL_ADDR = 13,
    parameter int DATA_ADDR = 14,
    parameter int DEVAD_OK  = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dir_wr,
    input logic              dir_rd,
    input logic [DIR_AW-1:0] dir_addr,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] ptr_q,
    input logic              ext_wr,
    input logic              ext_rd,
    input logic [DATA_W-1:0] ext_addr
);
    logic win_hit, dev_ok, foreign;
    logic [1:0] fn_bits;

    // Shorthand terms derived from ports and state.
    always_comb begin
        fn_bits = ctrl_q[DATA_W-1 -: 2];
        dev_ok  = (ctrl_q[4:0] == 5'(DEVAD_OK));
        win_hit = (dir_wr | dir_rd) & (dir_addr == DIR_AW'(DATA_ADDR));
        foreign = (dir_wr | dir_rd) & (dir_addr != DIR_AW'(DATA_ADDR))
                                    & (dir_addr != DIR_AW'(CTRL_ADDR));
    end

    p_ext_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_wr, ext_rd}));

    p_devad_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr | ext_rd) |-> dev_ok);

    p_self_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_wr | ext_rd) |-> (ext_addr != DATA_W'(CTRL_ADDR) && ext_addr != DATA_W'(DATA_ADDR)));

    p_adv_rw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && dev_ok && fn_bits == 2'b10) |=> (ptr_q == $past(ptr_q) + DATA_W'(1)));

    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && !dir_wr && dev_ok && fn_bits == 2'b11) |=> $stable(ptr_q));

    p_no_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && dev_ok && fn_bits == 2'b01) |=> $stable(ptr_q));

    p_foreign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        foreign |=> ($stable(ptr_q) && $stable(ctrl_q)));
endmodule

bind xreg_window xw_checker #(
    .DATA_W(DATA_W), .DIR_AW(DIR_AW), .CTRL_ADDR(CTRL_ADDR),
    .DATA_ADDR(DATA_ADDR), .DEVAD_OK(DEVAD_OK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dir_rd(dir_rd),
    .dir_addr(dir_addr), .ctrl_q(ctrl_q), .ptr_q(ptr_q),
    .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_addr(ext_addr)
);

// File: tb/test_xreg_window.sv
// Self-checking bench: sweeps every function code, device address and direction.
module test_xreg_window;
    localparam logic [15:0] MASK = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_wr = 1'b0, dir_rd = 1'b0;
    logic [4:0]  dir_addr = '0;
    logic [15:0] dir_wdata = '0;
    logic [15:0] dir_rdata, ext_addr, ext_wdata, ext_rdata;
    logic        ext_wr, ext_rd;

    int n_chk = 0, n_fail = 0;
    logic [15:0] s_rdata, s_eaddr, s_ewdata;
    logic        s_ewr, s_erd;

    always #2 clk = ~clk;

    // Extended register file model: contents derived from the address.
    assign ext_rdata = ext_addr ^ MASK;

    xreg_window i_xreg_window (
        .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dir_rd(dir_rd),
        .dir_addr(dir_addr), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
        .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic r, input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        dir_wr = w; dir_rd = r; dir_addr = a; dir_wdata = d;
        #1;
        s_rdata = dir_rdata; s_ewr = ext_wr; s_erd = ext_rd;
        s_eaddr = ext_addr; s_ewdata = ext_wdata;
        @(posedge clk);
        #1;
        dir_wr = 1'b0; dir_rd = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        acc(1, 0, 5'd13, 16'h001F);
        acc(1, 0, 5'd14, p);
    endtask

    task automatic get_ptr();
        acc(1, 0, 5'd13, 16'h001F);
        acc(0, 1, 5'd14, 16'h0000);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state.
        acc(0, 1, 5'd13, 0);
        check("R1 ctrl", s_rdata, 16'h0000);
        get_ptr();
        check("R1 ptr", s_rdata, 16'h0000);

        // R2: control register stores every bit.
        for (int i = 0; i < 16; i++) begin
            logic [15:0] v;
            v = (16'h1 << i) ^ 16'h1234;
            acc(1, 0, 5'd13, v);
            acc(0, 1, 5'd13, 0);
            check("R2 ctrl readback", s_rdata, v);
        end

        // R3: pointer mode load and read, repeated overwrite.
        for (int i = 0; i < 8; i++) begin
            logic [15:0] v;
            v = 16'h0F0F * 16'(i + 1);
            set_ptr(v);
            acc(0, 1, 5'd14, 0);
            check("R3 ptr read", s_rdata, v);
            check("R3 no ext", {s_ewr, s_erd}, 2'b00);
        end

        // R10: foreign direct addresses.
        set_ptr(16'h4321);
        acc(1, 0, 5'd13, 16'h401F);
        for (int a = 0; a < 32; a++) begin
            if (a != 13 && a != 14) begin
                acc(1, 0, 5'(a), 16'hFFFF);
                acc(0, 1, 5'(a), 0);
                check("R10 foreign read", s_rdata, 0);
            end
        end
        acc(0, 1, 5'd13, 0);
        check("R10 ctrl kept", s_rdata, 16'h401F);
        get_ptr();
        check("R10 ptr kept", s_rdata, 16'h4321);

        // R3..R7: full sweep of function code x device address x direction.
        for (int fn = 0; fn < 4; fn++) begin
            for (int dv = 0; dv < 32; dv++) begin
                for (int op = 0; op < 2; op++) begin
                    logic [15:0] p, d, ctl, ep, er;
                    logic ok;
                    string rq;
                    p   = 16'h0200 + 16'(fn * 80 + dv * 2 + op);
                    d   = ~p ^ 16'h0F00;
                    ctl = {2'(fn), 9'b0, 5'(dv)};
                    ok  = (dv == 31);
                    rq  = !ok ? "R7" : fn == 0 ? "R3" : fn == 1 ? "R4" : fn == 2 ? "R5" : "R6";
                    set_ptr(p);
                    acc(1, 0, 5'd13, ctl);
                    acc(op == 0, op == 1, 5'd14, d);
                    check({rq, " ext_wr"}, s_ewr, ok && fn != 0 && op == 0);
                    check({rq, " ext_rd"}, s_erd, ok && fn != 0 && op == 1);
                    if (s_ewr || s_erd) check({rq, " ext_addr"}, s_eaddr, p);
                    if (s_ewr) check({rq, " ext_wdata"}, s_ewdata, d);
                    er = (op == 1 && ok) ? (fn == 0 ? p : p ^ MASK) : 16'h0000;
                    check({rq, " rdata"}, s_rdata, er);
                    ep = p;
                    if (ok) begin
                        if (fn == 0 && op == 0) ep = d;
                        else if (fn == 2) ep = p + 1;
                        else if (fn == 3 && op == 0) ep = p + 1;
                    end
                    get_ptr();
                    check({rq, " pointer after"}, s_rdata, ep);
                end
            end
        end

        // R5: streaming reads walk upward, each using the old pointer.
        set_ptr(16'h7000);
        acc(1, 0, 5'd13, 16'h801F);
        for (int i = 0; i < 4; i++) begin
            acc(0, 1, 5'd14, 0);
            check("R5 stream addr", s_eaddr, 16'h7000 + 16'(i));
            check("R5 stream data", s_rdata, (16'h7000 + 16'(i)) ^ MASK);
        end

        // R4: repeated writes hit the same register.
        set_ptr(16'h1111);
        acc(1, 0, 5'd13, 16'h401F);
        for (int i = 0; i < 3; i++) begin
            acc(1, 0, 5'd14, 16'(i));
            check("R4 same target", s_eaddr, 16'h1111);
        end

        // R8: pointer on the window's own addresses.
        set_ptr(16'd13);
        acc(1, 0, 5'd13, 16'h801F);
        acc(0, 1, 5'd14, 0);
        check("R8 self read data", s_rdata, 0);
        check("R8 self no strobe", {s_ewr, s_erd}, 2'b00);
        acc(1, 0, 5'd14, 16'hBEEF);
        check("R8 self write no strobe", {s_ewr, s_erd}, 2'b00);
        get_ptr();
        check("R8 pointer advanced", s_rdata, 16'd15);

        // R9: wrap from the top of the space.
        set_ptr(16'hFFFF);
        acc(1, 0, 5'd13, 16'hC01F);
        acc(1, 0, 5'd14, 16'hAAAA);
        check("R9 old pointer used", s_eaddr, 16'hFFFF);
        get_ptr();
        check("R9 wrap", s_rdata, 16'h0000);

        // R11: both strobes act as a write.
        set_ptr(16'h3000);
        acc(1, 0, 5'd13, 16'hC01F);
        acc(1, 1, 5'd14, 16'h5555);
        check("R11 strobes", {s_ewr, s_erd}, 2'b10);
        check("R11 rdata", s_rdata, 0);
        get_ptr();
        check("R11 write advance", s_rdata, 16'h3001);

        finish_up();
    end
endmodule